// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a test function that sits behind a word-indexed register bus. A host uses it to check an endpoint's data path and interrupt delivery. Software sets source and destination buffer addresses, a byte count, a checksum and an interrupt selection. It then writes a command word. The engine reads a host buffer and verifies its checksum, fills a host buffer with a known pattern, or copies one host buffer to another. Each of these transfers runs over a simple request/acknowledge memory port. A command can also ask for a bare interrupt.

When the work is done, the engine writes a per-operation result into a status word and, if the selected interrupt number is legal, emits a one-cycle interrupt request. The request carries a kind (legacy, MSI or MSI-X) and a number. Link, packet and capability-structure handling belong to neighbouring blocks.

Top module: `ep_test_engine`

## Requirements
- R1: Registers are reached by word index: 0 scratch pattern, 1 command, 2 status, 3 source address, 4 destination address, 5 byte size, 6 checksum, 7 interrupt type, 8 interrupt number. All of them reset to zero. Index 0 reads back whatever was last written to it.
- R2: Command bits are: bit 0 legacy interrupt, bit 1 MSI, bit 2 MSI-X, bit 3 read, bit 4 write, bit 5 copy. Only the highest-priority request runs, in the order copy, write, read, bare interrupt. Among the interrupt bits, the lowest set bit picks the kind. The command register reads zero once the engine has taken the command.
- R3: A read fetches size/4 words (the low two size bits are ignored) from source+4·i. It sets status bit 0 if their 32-bit sum equals the checksum register, and bit 1 if it does not.
- R4: A write stores the value i at destination+4·i for i below size/4. It loads the sum of those values into the checksum register and sets status bit 2.
- R5: A copy moves size/4 words from source+4·i to destination+4·i and sets status bit 4.
- R6: An address is invalid when it is zero or has either of its two low bits set. An invalid address sets the operation's fail bit (read 1, write 3, copy 5) together with status bit 7 for the source or bit 8 for the destination. No memory access is made, and the interrupt is still raised.
- R7: Status is cleared when a command is taken. Command writes made while an operation is in progress are ignored.
- R8: Interrupt type 0 selects legacy, 1 selects MSI and 2 selects MSI-X. A finished read, write or copy raises the kind named by the type register. The request carries the interrupt-number register and sets status bit 6.
- R9: Legal numbers are 0 for legacy, 1 to 32 for MSI and 1 to 2048 for MSI-X; a type of 3 or more is never legal. An illegal number, or an illegal type, raises no request and leaves status bit 6 clear.
- R10: The interrupt request is high for exactly one cycle. Its kind and number are valid in that same cycle.
- R11: A memory request stays high, with its address, direction and write data unchanged, until it is acknowledged. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | 0 legacy, 1 MSI, 2 MSI-X |
| irq_num | output | 12 | Interrupt number |

## Verification
The assertions take three things for granted about the inputs. The memory side raises mem_ack only while a request is pending. Software does not rewrite the size, address or checksum registers while an operation is in progress. The request-hold property also depends on the acknowledge arriving only for an outstanding request. The bench's memory model answers one cycle after it sees a request and then drops the acknowledge. All register changes are made while the engine is idle, except one deliberate command write issued mid-operation.

// File: rtl/ep_test_engine.sv
module ep_test_engine #(
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048,
  parameter int NUM_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             irq_pulse,
  output logic [1:0]       irq_kind,
  output logic [NUM_W-1:0] irq_num
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_CR, S_CW, S_FIN} state_t;
  state_t state;

  logic [31:0] pat, src, dst, size, csum, ityp, inum, acc, hold;
  logic [5:0]  cmd;
  logic [8:0]  stat;
  logic [29:0] cnt;
  logic [1:0]  fin_kind;
  logic        fin_typ_ok;

  wire [29:0] nwords  = size[31:2];
  wire        done    = (cnt == nwords);
  wire        bad_src = (src == 32'd0) || (src[1:0] != 2'b00);
  wire        bad_dst = (dst == 32'd0) || (dst[1:0] != 2'b00);
  wire [31:0] off     = {cnt, 2'b00};

  logic num_ok;
  always_comb begin
    case (fin_kind)
      2'd0:    num_ok = (inum == 32'd0);
      2'd1:    num_ok = (inum >= 32'd1) && (inum <= 32'(MSI_MAX));
      2'd2:    num_ok = (inum >= 32'd1) && (inum <= 32'(MSIX_MAX));
      default: num_ok = 1'b0;
    endcase
  end
  wire irq_ok = fin_typ_ok && num_ok;

  assign mem_req   = (state == S_CW) ||
                     (((state == S_RD) || (state == S_WR) || (state == S_CR)) && !done);
  assign mem_we    = (state == S_WR) || (state == S_CW);
  assign mem_addr  = ((state == S_RD) || (state == S_CR)) ? src + off : dst + off;
  assign mem_wdata = (state == S_WR) ? {2'b00, cnt} : hold;

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = pat;
      4'd1:    reg_rdata = {26'd0, cmd};
      4'd2:    reg_rdata = {23'd0, stat};
      4'd3:    reg_rdata = src;
      4'd4:    reg_rdata = dst;
      4'd5:    reg_rdata = size;
      4'd6:    reg_rdata = csum;
      4'd7:    reg_rdata = ityp;
      4'd8:    reg_rdata = inum;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pat <= '0; cmd <= '0; stat <= '0; src <= '0; dst <= '0;
      size <= '0; csum <= '0; ityp <= '0; inum <= '0;
      acc <= '0; hold <= '0; cnt <= '0;
      fin_kind <= '0; fin_typ_ok <= 1'b0;
      irq_pulse <= 1'b0; irq_kind <= '0; irq_num <= '0;
    end else begin
      irq_pulse <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          4'd0: pat  <= reg_wdata;
          4'd1: if (state == S_IDLE && cmd == 6'd0) cmd <= reg_wdata[5:0];
          4'd3: src  <= reg_wdata;
          4'd4: dst  <= reg_wdata;
          4'd5: size <= reg_wdata;
          4'd6: csum <= reg_wdata;
          4'd7: ityp <= reg_wdata;
          4'd8: inum <= reg_wdata;
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (cmd != 6'd0) begin
          cmd  <= '0;
          stat <= '0;
          acc  <= '0;
          cnt  <= '0;
          fin_kind   <= ityp[1:0];
          fin_typ_ok <= (ityp < 32'd3);
          if (cmd[5]) begin
            if (bad_src || bad_dst) begin
              stat[5] <= 1'b1; stat[7] <= bad_src; stat[8] <= bad_dst;
              state <= S_FIN;
            end else state <= S_CR;
          end else if (cmd[4]) begin
            if (bad_dst) begin
              stat[3] <= 1'b1; stat[8] <= 1'b1; state <= S_FIN;
            end else state <= S_WR;
          end else if (cmd[3]) begin
            if (bad_src) begin
              stat[1] <= 1'b1; stat[7] <= 1'b1; state <= S_FIN;
            end else state <= S_RD;
          end else begin
            fin_kind   <= cmd[0] ? 2'd0 : (cmd[1] ? 2'd1 : 2'd2);
            fin_typ_ok <= 1'b1;
            state <= S_FIN;
          end
        end
        S_RD: if (done) begin
          stat[0] <= (acc == csum);
          stat[1] <= (acc != csum);
          state   <= S_FIN;
        end else if (mem_ack) begin
          acc <= acc + mem_rdata;
          cnt <= cnt + 30'd1;
        end
        S_WR: if (done) begin
          csum    <= acc;
          stat[2] <= 1'b1;
          state   <= S_FIN;
        end else if (mem_ack) begin
          acc <= acc + {2'b00, cnt};
          cnt <= cnt + 30'd1;
        end
        S_CR: if (done) begin
          stat[4] <= 1'b1;
          state   <= S_FIN;
        end else if (mem_ack) begin
          hold  <= mem_rdata;
          state <= S_CW;
        end
        S_CW: if (mem_ack) begin
          cnt   <= cnt + 30'd1;
          state <= S_CR;
        end
        S_FIN: begin
          if (irq_ok) begin
            irq_pulse <= 1'b1;
            irq_kind  <= fin_kind;
            irq_num   <= inum[NUM_W-1:0];
            stat[6]   <= 1'b1;
          end
          state <= S_FIN == state ? S_IDLE : state;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r9_irq_number_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ((irq_kind == 2'd0 && irq_num == '0) ||
                   (irq_kind == 2'd1 && irq_num >= NUM_W'(1) && irq_num <= NUM_W'(MSI_MAX)) ||
                   (irq_kind == 2'd2 && irq_num >= NUM_W'(1) && irq_num <= NUM_W'(MSIX_MAX))));

  a_r8_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> stat[6]);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r6_bad_addr_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] || stat[8]) |-> !mem_req);

  a_r3_result_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[0] && stat[1]) && !(stat[2] && stat[3]) && !(stat[4] && stat[5]));

  a_r2_cmd_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && cmd != 6'd0) |=> (state != S_IDLE && cmd == 6'd0));

endmodule

// File: tb/ep_test_engine_test.sv
module ep_test_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack, irq_pulse;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] irq_kind;
  logic [11:0] irq_num;

  always #10 clk = ~clk;

  ep_test_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq_pulse(irq_pulse),
    .irq_kind(irq_kind), .irq_num(irq_num));

  logic [31:0] mem [0:255];
  int accesses = 0, pulses = 0, double_pulse = 0;
  logic [1:0] last_kind = '0;
  logic [11:0] last_num = '0;
  logic prev_pulse = 1'b0;
  int tests = 0, fails = 0;

  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
      mem_ack <= 1'b1;
      accesses <= accesses + 1;
    end else mem_ack <= 1'b0;
    if (irq_pulse) begin
      pulses <= pulses + 1;
      last_kind <= irq_kind;
      last_num <= irq_num;
      if (prev_pulse) double_pulse <= double_pulse + 1;
    end
    prev_pulse <= irq_pulse;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(idx);
    #1 v = reg_rdata;
  endtask

  task automatic run(input logic [5:0] c);
    wr(1, {26'd0, c});
    repeat (120) @(negedge clk);
  endtask

  function automatic logic [31:0] sum_words(input int base, input int n);
    logic [31:0] s = 0;
    for (int i = 0; i < n; i++) s += mem[base + i];
    return s;
  endfunction

  initial begin
    #3000000;
    fails++; tests++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, s;
    int p0, a0;
    for (int i = 0; i < 256; i++) mem[i] = i * 7 + 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int r = 0; r <= 8; r++) begin rd(r, v); chk("R1 reset reg", v, 0); end
    chk("R1 reset irq/mem", {31'd0, irq_pulse | mem_req}, 0);
    foreach (v[b]) begin
      wr(0, 32'h1 << b); rd(0, v); chk("R1 pattern walk", v, 32'h1 << b);
    end
    wr(0, 32'hA5A5_5A5A); rd(0, v); chk("R1 pattern", v, 32'hA5A5_5A5A);

    // R3 read with good and bad checksum, type legacy number 0
    wr(7, 0); wr(8, 0); wr(3, 32'h100);
    for (int n = 0; n <= 8; n++) begin
      for (int bad = 0; bad < 2; bad++) begin
        wr(5, n * 4 + bad * 3);
        wr(6, sum_words(64, n) + bad);
        p0 = pulses; a0 = accesses;
        run(6'h08);
        rd(2, v); chk("R3 read status", v, bad ? 32'h42 : 32'h41);
        chk("R3 read accesses", accesses - a0, n);
        chk("R8 read irq", pulses - p0, 1);
        rd(1, v); chk("R2 cmd self-clear", v, 0);
      end
    end

    // R4 write pattern
    wr(4, 32'h200);
    for (int n = 0; n <= 8; n++) begin
      mem[128 + n] = 32'hDEAD_0000 + n;
      wr(5, n * 4);
      run(6'h10);
      rd(2, v); chk("R4 write status", v, 32'h44);
      rd(6, v); chk("R4 checksum", v, n * (n - 1) / 2);
      for (int i = 0; i < n; i++) chk("R4 write data", mem[128 + i], i);
      chk("R4 no overrun", mem[128 + n], 32'hDEAD_0000 + n);
    end

    // R5 copy
    wr(3, 32'h100); wr(4, 32'h300);
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < 16; i++) mem[192 + i] = 0;
      wr(5, n * 4);
      run(6'h20);
      rd(2, v); chk("R5 copy status", v, 32'h50);
      for (int i = 0; i < n; i++) chk("R5 copy data", mem[192 + i], mem[64 + i]);
      chk("R5 copy bound", mem[192 + n], 0);
    end

    // R6 invalid addresses
    wr(5, 16);
    for (int k = 0; k < 7; k++) begin
      logic [31:0] badaddr;
      badaddr = (k == 0) ? 32'h0 : (k < 4 ? 32'(k) : 32'h40 + 32'(k - 3));
      wr(3, badaddr); wr(4, 32'h300);
      p0 = pulses; a0 = accesses;
      run(6'h08); rd(2, v); chk("R6 read bad src", v, 32'hC2);
      run(6'h20); rd(2, v); chk("R6 copy bad src", v, 32'hE0);
      wr(4, badaddr);
      run(6'h10); rd(2, v); chk("R6 write bad dst", v, 32'h148);
      run(6'h20); rd(2, v); chk("R6 copy both bad", v, 32'h1E0);
      wr(3, 32'h100);
      run(6'h20); rd(2, v); chk("R6 copy bad dst", v, 32'h160);
      chk("R6 no access", accesses - a0, 0);
      chk("R6 irq raised", pulses - p0, 5);
    end

    // R8/R9 type x number sweep through read of size 0
    wr(3, 32'h100); wr(5, 0); wr(6, 0);
    for (int t = 0; t < 4; t++) begin
      int nums[7] = '{0, 1, 2, 32, 33, 2048, 2049};
      foreach (nums[j]) begin
        logic ok;
        ok = (t == 0 && nums[j] == 0) || (t == 1 && nums[j] >= 1 && nums[j] <= 32) ||
             (t == 2 && nums[j] >= 1 && nums[j] <= 2048);
        wr(7, t); wr(8, nums[j]);
        p0 = pulses;
        run(6'h08);
        rd(2, v); chk("R9 status bit6", v, ok ? 32'h41 : 32'h01);
        chk("R9 pulse count", pulses - p0, ok ? 1 : 0);
        if (ok) begin
          chk("R8 irq kind", {30'd0, last_kind}, t);
          chk("R8 irq num", {20'd0, last_num}, nums[j]);
        end
      end
    end

    // R2 priority over every command value
    wr(3, 32'h100); wr(4, 32'h380); wr(5, 8); wr(7, 0); wr(8, 0);
    for (int c = 1; c < 64; c++) begin
      logic [31:0 ] e;
      wr(6, sum_words(64, 2));
      p0 = pulses;
      run(6'(c));
      if (c & 32) e = 32'h50;
      else if (c & 16) e = 32'h44;
      else if (c & 8) e = 32'h41;
      else e = (c & 1) ? 32'h40 : 32'h0;
      rd(2, v); chk("R2 priority status", v, e);
      chk("R2 priority pulses", pulses - p0, (e[6]) ? 1 : 0);
      if ((c & 56) == 0 && e[6]) chk("R2 bare kind", {30'd0, last_kind}, 0);
    end

    // R2 bare interrupt kind from lowest bit, number 5
    wr(8, 5);
    for (int c = 1; c < 8; c++) begin
      int k;
      k = (c & 1) ? 0 : ((c & 2) ? 1 : 2);
      p0 = pulses;
      run(6'(c));
      chk("R2 bare pulses", pulses - p0, (k == 0) ? 0 : 1);
      rd(2, v); chk("R2 bare status", v, (k == 0) ? 0 : 32'h40);
      if (k != 0) chk("R2 bare kind", {30'd0, last_kind}, k);
    end

    // R7 command ignored while busy
    wr(7, 0); wr(8, 0); wr(4, 32'h200); wr(5, 32);
    p0 = pulses;
    wr(1, 32'h10);
    repeat (3) @(negedge clk);
    wr(1, 32'h08);
    rd(1, v); chk("R7 busy cmd ignored", v, 0);
    repeat (150) @(negedge clk);
    rd(2, v); chk("R7 status after busy", v, 32'h44);
    chk("R7 single op", pulses - p0, 1);
    chk("R10 pulse width", double_pulse, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule